// File: doc/BRIEF.md
# Dual-Channel Serial Register Block

This block holds the control and interrupt registers of a two-channel asynchronous serial controller behind a byte-wide register bus. Each channel has a command register that switches its receiver and transmitter on and off, a status register, and a holding register. Reading the holding register returns the last accepted received byte. Writing it raises a one-cycle transmit strobe toward the shifter. Shifting and baud timing live elsewhere. Received bytes arrive on a valid/data pair per channel.

An interrupt status register gathers the per-channel ready bits. A mask register selects which of them drive a level interrupt request. A vector register supplies the vector that is reported with the request, and the request always carries a fixed priority of 4. The request follows the masked status level. Reading the interrupt status register has no side effect.

Read data is combinational from the address. Register writes, read side effects and received bytes take effect at the rising clock edge.

Top module: `ser_regs`

## Requirements
- R1: After reset, every status, interrupt status, mask and vector register reads 0, both receivers and transmitters are off, and irq_o is low.
- R2: Command register bits [1:0] are the receiver command: code 01 enables the receiver, code 10 disables it, and codes 00 and 11 leave it unchanged.
- R3: Command register bits [3:2] are the transmitter command. Code 01 enables the transmitter and sets status bits 2 (transmit-ready) and 3 (transmit-empty) plus that channel's transmit interrupt bit. Code 10 disables the transmitter and clears those three bits.
- R4: A received byte is accepted only while the channel's receiver is enabled and status bit 0 (receive-ready) is clear. Acceptance stores the byte and sets receive-ready and the channel's receive interrupt bit. A byte that arrives while the channel is full or its receiver is off is dropped.
- R5: A read of a channel's holding register returns the stored byte and clears its receive-ready bit and its receive interrupt bit.
- R6: A read of the interrupt status register returns its value and leaves it unchanged.
- R7: Interrupt status layout: bit 0 is channel A transmit, bit 1 is channel A receive, bit 4 is channel B transmit, bit 5 is channel B receive, and the other bits read 0. irq_o goes high one clock after (status AND mask) becomes nonzero and goes low one clock after it returns to zero.
- R8: irq_level_o is 4. irq_vector_o shows the vector register, and the vector and mask registers read back the values written to them.
- R9: A write to a channel's holding register pulses that channel's tx_wr_o bit with tx_data_o equal to the written byte, but only while that channel's transmitter is enabled.
- R10: Address map: channel A has status 0x0 (read), command 0x1 (write) and holding 0x2. Channel B has the same registers at 0x4, 0x5 and 0x6. Interrupt status is at 0x8 (read), mask at 0x9 and vector at 0xA. Reads of any other address return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 4 | Register address |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe (enables read side effects) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i (combinational) |
| rx_valid_i | input | 2 | Received byte valid, one bit per channel |
| rx_data_i | input | 16 | Received bytes, channel B in [15:8], channel A in [7:0] |
| tx_wr_o | output | 2 | Transmit strobe, one bit per channel |
| tx_data_o | output | 8 | Byte to transmit |
| irq_o | output | 1 | Level interrupt request |
| irq_level_o | output | 3 | Interrupt priority (always 4) |
| irq_vector_o | output | 8 | Interrupt vector |

## Verification
The assertions check the interrupt level on every cycle: it must rise or fall one clock after the masked status changes. They also check that the command codes 01 and 10 reach the enables and the transmit bits, that a holding-register read clears the receive bit, that an interrupt-status read leaves the register unchanged, and that no transmit strobe occurs while a transmitter is off. Some behaviour can only be shown by the bench's scenarios. These are that a second byte arriving while the channel is full is dropped and the first byte is kept, that codes 00 and 11 leave the receiver unchanged, that the exact status and interrupt-status byte values are correct, that unmapped addresses read zero, and that both channels work independently.

// File: rtl/ser_pkg.sv
package ser_pkg;
  localparam int NUM_CH = 2;
  localparam int DW     = 8;
  localparam int AW     = 4;
  localparam int ISR_STRIDE = 4;

  // channel-local register offsets (addr[1:0]); addr[2] selects channel
  localparam logic [1:0] OFS_STAT = 2'd0;
  localparam logic [1:0] OFS_CMD  = 2'd1;
  localparam logic [1:0] OFS_HOLD = 2'd2;

  localparam logic [AW-1:0] ADR_ISR = 4'h8;
  localparam logic [AW-1:0] ADR_IMR = 4'h9;
  localparam logic [AW-1:0] ADR_IVR = 4'hA;

  localparam int ST_RXRDY = 0;
  localparam int ST_TXRDY = 2;
  localparam int ST_TXEMT = 3;

  localparam int ISR_TX = 0;
  localparam int ISR_RX = 1;

  localparam logic [1:0] CMD_ON  = 2'b01;
  localparam logic [1:0] CMD_OFF = 2'b10;

  localparam logic [2:0] IRQ_PRIO = 3'd4;
endpackage

// File: rtl/ser_chan.sv
module ser_chan
  import ser_pkg::*;
#(
  parameter int W = DW
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cmd_we_i,
  input  logic [3:0]   cmd_i,
  input  logic         hold_rd_i,
  input  logic         rx_valid_i,
  input  logic [W-1:0] rx_data_i,
  output logic [7:0]   status_o,
  output logic [W-1:0] hold_o,
  output logic         rx_en_o,
  output logic         tx_en_o
);
  logic rx_en_q, tx_en_q, rxrdy_q, txrdy_q;
  logic [W-1:0] hold_q;
  logic accept;

  assign accept = rx_en_q && !rxrdy_q && rx_valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_en_q <= 1'b0;
      tx_en_q <= 1'b0;
      rxrdy_q <= 1'b0;
      txrdy_q <= 1'b0;
      hold_q  <= '0;
    end else begin
      if (cmd_we_i) begin
        if (cmd_i[1:0] == CMD_ON)       rx_en_q <= 1'b1;
        else if (cmd_i[1:0] == CMD_OFF) rx_en_q <= 1'b0;
        if (cmd_i[3:2] == CMD_ON) begin
          tx_en_q <= 1'b1;
          txrdy_q <= 1'b1;
        end else if (cmd_i[3:2] == CMD_OFF) begin
          tx_en_q <= 1'b0;
          txrdy_q <= 1'b0;
        end
      end
      // an accepted byte wins over a simultaneous holding read
      if (accept) begin
        hold_q  <= rx_data_i;
        rxrdy_q <= 1'b1;
      end else if (hold_rd_i) begin
        rxrdy_q <= 1'b0;
      end
    end
  end

  always_comb begin
    status_o           = '0;
    status_o[ST_RXRDY] = rxrdy_q;
    status_o[ST_TXRDY] = txrdy_q;
    status_o[ST_TXEMT] = txrdy_q; // no shifter here: empty tracks ready
  end

  assign hold_o  = hold_q;
  assign rx_en_o = rx_en_q;
  assign tx_en_o = tx_en_q;
endmodule

// File: rtl/ser_irq.sv
module ser_irq
  import ser_pkg::*;
#(
  parameter int W = DW
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         imr_we_i,
  input  logic         ivr_we_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] isr_i,
  output logic [W-1:0] imr_o,
  output logic [W-1:0] ivr_o,
  output logic         irq_o
);
  logic [W-1:0] imr_q, ivr_q;
  logic irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      imr_q <= '0;
      ivr_q <= '0;
      irq_q <= 1'b0;
    end else begin
      if (imr_we_i) imr_q <= wdata_i;
      if (ivr_we_i) ivr_q <= wdata_i;
      irq_q <= |(isr_i & imr_q);
    end
  end

  assign imr_o = imr_q;
  assign ivr_o = ivr_q;
  assign irq_o = irq_q;
endmodule

// File: rtl/ser_regs.sv
module ser_regs
  import ser_pkg::*;
#(
  parameter logic [2:0] IRQ_LEVEL = IRQ_PRIO
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [AW-1:0]        addr_i,
  input  logic                 wr_i,
  input  logic                 rd_i,
  input  logic [DW-1:0]        wdata_i,
  output logic [DW-1:0]        rdata_o,
  input  logic [NUM_CH-1:0]    rx_valid_i,
  input  logic [NUM_CH*DW-1:0] rx_data_i,
  output logic [NUM_CH-1:0]    tx_wr_o,
  output logic [DW-1:0]        tx_data_o,
  output logic                 irq_o,
  output logic [2:0]           irq_level_o,
  output logic [DW-1:0]        irq_vector_o
);
  logic [7:0]    st_w   [NUM_CH];
  logic [DW-1:0] hold_w [NUM_CH];
  logic [NUM_CH-1:0] rx_en_w, tx_en_w, ch_sel;
  logic [DW-1:0] isr_w, imr_w, ivr_w;
  logic          is_chan;
  logic [1:0]    ofs;

  assign is_chan = !addr_i[AW-1];
  assign ofs     = addr_i[1:0];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign ch_sel[c] = is_chan && (addr_i[2] == c[0]);

    ser_chan #(.W(DW)) u_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .cmd_we_i   (wr_i && ch_sel[c] && ofs == OFS_CMD),
      .cmd_i      (wdata_i[3:0]),
      .hold_rd_i  (rd_i && ch_sel[c] && ofs == OFS_HOLD),
      .rx_valid_i (rx_valid_i[c]),
      .rx_data_i  (rx_data_i[c*DW +: DW]),
      .status_o   (st_w[c]),
      .hold_o     (hold_w[c]),
      .rx_en_o    (rx_en_w[c]),
      .tx_en_o    (tx_en_w[c])
    );

    assign tx_wr_o[c] = wr_i && ch_sel[c] && ofs == OFS_HOLD && tx_en_w[c];
  end

  always_comb begin
    isr_w = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      isr_w[c*ISR_STRIDE + ISR_TX] = st_w[c][ST_TXRDY];
      isr_w[c*ISR_STRIDE + ISR_RX] = st_w[c][ST_RXRDY];
    end
  end

  ser_irq #(.W(DW)) u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .imr_we_i (wr_i && addr_i == ADR_IMR),
    .ivr_we_i (wr_i && addr_i == ADR_IVR),
    .wdata_i  (wdata_i),
    .isr_i    (isr_w),
    .imr_o    (imr_w),
    .ivr_o    (ivr_w),
    .irq_o    (irq_o)
  );

  always_comb begin
    rdata_o = '0;
    if (is_chan) begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (ch_sel[c]) begin
          if (ofs == OFS_STAT)      rdata_o = st_w[c];
          else if (ofs == OFS_HOLD) rdata_o = hold_w[c];
        end
      end
    end else begin
      case (addr_i)
        ADR_ISR: rdata_o = isr_w;
        ADR_IMR: rdata_o = imr_w;
        ADR_IVR: rdata_o = ivr_w;
        default: rdata_o = '0;
      endcase
    end
  end

  assign tx_data_o    = wdata_i;
  assign irq_level_o  = IRQ_LEVEL;
  assign irq_vector_o = ivr_w;
endmodule

// File: rtl/ser_regs_chk.sv
module ser_regs_chk
  import ser_pkg::*;
(
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [AW-1:0]        addr_i,
  input logic                 wr_i,
  input logic                 rd_i,
  input logic [DW-1:0]        wdata_i,
  input logic [NUM_CH-1:0]    rx_valid_i,
  input logic [NUM_CH-1:0]    tx_wr_o,
  input logic                 irq_o,
  input logic [DW-1:0]        irq_vector_o,
  input logic [DW-1:0]        isr_i,
  input logic [DW-1:0]        imr_i,
  input logic [NUM_CH-1:0]    rx_en_i,
  input logic [NUM_CH-1:0]    tx_en_i
);
  AST_IRQ_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(isr_i & imr_i)) |=> irq_o); // R7
  AST_IRQ_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|(isr_i & imr_i)) |=> !irq_o); // R7
  AST_VEC_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == ADR_IVR) |=> irq_vector_o == $past(wdata_i)); // R8
  AST_RXA_ENABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == 4'h1 && wdata_i[1:0] == CMD_ON) |=> rx_en_i[0]); // R2
  AST_RXB_DISABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == 4'h5 && wdata_i[1:0] == CMD_OFF) |=> !rx_en_i[1]); // R2
  AST_TXA_DISABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == 4'h1 && wdata_i[3:2] == CMD_OFF) |=> !isr_i[ISR_TX] && !tx_en_i[0]); // R3
  AST_RXA_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == 4'h2 && !rx_valid_i[0]) |=> !isr_i[ISR_RX]); // R5
  AST_RXB_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == 4'h6 && !rx_valid_i[1]) |=> !isr_i[ISR_STRIDE + ISR_RX]); // R5
  AST_ISR_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !wr_i && addr_i == ADR_ISR && rx_valid_i == '0) |=> $stable(isr_i)); // R6
  AST_TX_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_wr_o & ~tx_en_i) == '0); // R9
endmodule

bind ser_regs ser_regs_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .addr_i       (addr_i),
  .wr_i         (wr_i),
  .rd_i         (rd_i),
  .wdata_i      (wdata_i),
  .rx_valid_i   (rx_valid_i),
  .tx_wr_o      (tx_wr_o),
  .irq_o        (irq_o),
  .irq_vector_o (irq_vector_o),
  .isr_i        (isr_w),
  .imr_i        (imr_w),
  .rx_en_i      (rx_en_w),
  .tx_en_i      (tx_en_w)
);

// File: tb/ser_regs_tb.sv
module ser_regs_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  addr_i = '0;
  logic        wr_i = 1'b0;
  logic        rd_i = 1'b0;
  logic [7:0]  wdata_i = '0;
  logic [7:0]  rdata_o;
  logic [1:0]  rx_valid_i = '0;
  logic [15:0] rx_data_i = '0;
  logic [1:0]  tx_wr_o;
  logic [7:0]  tx_data_o;
  logic        irq_o;
  logic [2:0]  irq_level_o;
  logic [7:0]  irq_vector_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #4 clk_i = ~clk_i; // 125 MHz

  ser_regs u_dut (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: compares read data against the scoreboard at mid-cycle
  always @(negedge clk_i) begin
    if (rst_ni && rd_i) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL scoreboard: unexpected read, actual %0h expected none", rdata_o);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rdata_o !== e) begin
          n_bad++;
          $display("FAIL %s: read %0h actual %0h expected %0h", t, addr_i, rdata_o, e);
        end
      end
    end
  end

  task automatic step();
    @(posedge clk_i);
    #1;
  endtask

  task automatic reg_wr(logic [3:0] a, logic [7:0] d);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    step();
    wr_i = 1'b0;
  endtask

  task automatic reg_rd(logic [3:0] a, logic [7:0] e, string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    addr_i = a; rd_i = 1'b1;
    step();
    rd_i = 1'b0;
  endtask

  task automatic rx_push(int ch, logic [7:0] d);
    rx_valid_i[ch] = 1'b1;
    rx_data_i[ch*8 +: 8] = d;
    step();
    rx_valid_i = '0;
  endtask

  task automatic tx_put(logic [3:0] a, logic [7:0] d, logic [1:0] exp_str, string tag);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    #2;
    chk({tag, " strobe"}, tx_wr_o, exp_str);
    if (exp_str != 0) chk({tag, " data"}, tx_data_o, d);
    step();
    wr_i = 1'b0;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #20 rst_ni = 1'b1;
    step();
    // R1 reset state
    reg_rd(4'h0, 8'h00, "R1 status A");
    reg_rd(4'h4, 8'h00, "R1 status B");
    reg_rd(4'h8, 8'h00, "R1 isr");
    reg_rd(4'h9, 8'h00, "R1 imr");
    reg_rd(4'hA, 8'h00, "R1 ivr");
    chk("R1 irq", irq_o, 0);
    tx_put(4'h2, 8'h7E, 2'b00, "R1 tx off");
    // R4 receiver off drops byte
    rx_push(0, 8'h55);
    reg_rd(4'h0, 8'h00, "R4 rx off");
    // R2 enable, R4 accept
    reg_wr(4'h1, 8'h01);
    rx_push(0, 8'h3C);
    reg_rd(4'h0, 8'h01, "R4 status A rxrdy");
    reg_rd(4'h8, 8'h02, "R6 isr first read");
    reg_rd(4'h8, 8'h02, "R6 isr second read");
    rx_push(0, 8'h99); // full: dropped
    reg_rd(4'h2, 8'h3C, "R4 hold keeps first");
    reg_rd(4'h0, 8'h00, "R5 rxrdy cleared");
    reg_rd(4'h8, 8'h00, "R5 isr rx cleared");
    // R2 code 11 keeps enabled
    reg_wr(4'h1, 8'h03);
    rx_push(0, 8'h11);
    reg_rd(4'h0, 8'h01, "R2 code 11 no change");
    reg_rd(4'h2, 8'h11, "R5 hold read");
    reg_wr(4'h1, 8'h02);
    rx_push(0, 8'h22);
    reg_rd(4'h0, 8'h00, "R2 disabled");
    reg_wr(4'h1, 8'h00);
    rx_push(0, 8'h23);
    reg_rd(4'h0, 8'h00, "R2 code 00 no change");
    // R3 / R9 transmitter
    tx_put(4'h2, 8'h41, 2'b00, "R9 tx disabled");
    reg_wr(4'h1, 8'h04);
    reg_rd(4'h0, 8'h0C, "R3 status A tx on");
    reg_rd(4'h8, 8'h01, "R3 isr A tx");
    tx_put(4'h2, 8'h41, 2'b01, "R9 tx A");
    tx_put(4'h6, 8'h42, 2'b00, "R9 tx B off");
    reg_wr(4'h5, 8'h04);
    reg_rd(4'h4, 8'h0C, "R3 status B tx on");
    reg_rd(4'h8, 8'h11, "R7 isr layout");
    tx_put(4'h6, 8'h42, 2'b10, "R9 tx B");
    reg_wr(4'h5, 8'h08);
    reg_rd(4'h4, 8'h00, "R3 status B tx off");
    reg_rd(4'h8, 8'h01, "R3 isr B tx cleared");
    // R8 vector and level
    reg_wr(4'hA, 8'h5A);
    reg_rd(4'hA, 8'h5A, "R8 ivr readback");
    chk("R8 vector", irq_vector_o, 8'h5A);
    chk("R8 level", irq_level_o, 3'd4);
    // R7 masking and timing
    reg_wr(4'h9, 8'h02);
    reg_rd(4'h9, 8'h02, "R8 imr readback");
    step();
    chk("R7 masked off", irq_o, 0);
    reg_wr(4'h9, 8'h01);
    chk("R7 not yet", irq_o, 0);
    step();
    chk("R7 rise", irq_o, 1);
    reg_rd(4'h8, 8'h01, "R6 isr read with irq");
    step();
    chk("R6 irq held", irq_o, 1);
    reg_wr(4'h1, 8'h08);
    chk("R7 fall not yet", irq_o, 1);
    step();
    chk("R7 fall", irq_o, 0);
    // channel B receive path
    reg_wr(4'h5, 8'h01);
    reg_wr(4'h9, 8'h20);
    rx_push(1, 8'h77);
    reg_rd(4'h4, 8'h01, "R4 status B rxrdy");
    chk("R7 irq B rx", irq_o, 1);
    reg_rd(4'h6, 8'h77, "R5 hold B");
    step();
    chk("R5 irq after B read", irq_o, 0);
    reg_rd(4'h8, 8'h00, "R5 isr B cleared");
    // R10 unmapped
    reg_rd(4'hF, 8'h00, "R10 unmapped F");
    reg_rd(4'h3, 8'h00, "R10 unmapped 3");
    reg_rd(4'h1, 8'h00, "R10 command reads 0");
    step();
    if (exp_q.size() != 0) chk("scoreboard drain", exp_q.size(), 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule